// File: doc/BRIEF.md
# Link Wake-Up Signal Generator

This block tells a sleeping link-layer controller to power up. It watches two inputs to decide whether the link is awake: a power-monitor status bit and a link-control register bit. While the link is not awake, a wake-up event asserts the wake-up indication. A wake-up event is either a received link-on packet addressed to this node or, when interrupt waking is enabled, a pending PHY interrupt. While the indication is asserted, the output pin carries a square wave rather than a level. The wave has `2*HALF_CYCLES` clock periods per cycle and starts with its high half. With the default of 4 and a 49.152 MHz clock, the period is about 163 ns.

The indication drops as soon as the link is awake again, which means both the status and the control bit are 1. A bus reset also drops it. The exception is a bus reset that arrives while an enabled interrupt is pending: in that case the interrupt would wake the link anyway, so the indication stays on. An event that arrives while the link is already awake has no effect and is not stored.

Control is a three-state machine:
- `WK_OFF`: the output is low.
- `WK_HIGH` and `WK_LOW`: the two halves of the wave.

The transitions are:
- **start** (`WK_OFF`→`WK_HIGH`) when the indication turns on.
- **fall** (`WK_HIGH`→`WK_LOW`) and **rise** (`WK_LOW`→`WK_HIGH`) each time a half-period counter expires.
- **stop** (`WK_HIGH`/`WK_LOW`→`WK_OFF`) when the indication turns off.

Top module: `link_wake_gen`

## Requirements
- R1: During and directly after the asynchronous active-low reset, the indication is off and `wake_o` is 0.
- R2: The link counts as awake only when `lps_ok_i` and `lctrl_i` are both 1. When either one is 0, a wake-up event turns the indication on.
- R3: A `linkon_pulse_i` high at a clock edge while the link is not awake drives `wake_o` to 1 after that edge.
- R4: `phy_irq_i` is a wake-up event only while `irq_wake_en_i` is 1. With the enable at 0, a pending interrupt leaves `wake_o` at 0.
- R5: While the indication is on, `wake_o` is 1 for HALF_CYCLES clocks and then 0 for HALF_CYCLES clocks, repeating. Each new turn-on starts with the high half.
- R6: At any clock edge where the link is awake, the indication turns off and `wake_o` is 0 after that edge.
- R7: `bus_reset_i` turns the indication off unless `phy_irq_i` and `irq_wake_en_i` are both 1 at that edge. If they are both 1, the wave continues unbroken.
- R8: A wake-up event at an edge where the link is awake is ignored and not remembered. Once the link is no longer awake, `wake_o` stays 0 until a new event arrives.
- R9: While the indication is off, `wake_o` is 0. Without an event, the indication stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (49.152 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| lps_ok_i | input | 1 | Power-monitor status: 1 when the link is powered |
| lctrl_i | input | 1 | Link-control register bit |
| linkon_pulse_i | input | 1 | One-cycle pulse: link-on packet for this node received |
| phy_irq_i | input | 1 | PHY interrupt condition pending (level) |
| irq_wake_en_i | input | 1 | Enables the PHY interrupt as a wake-up event |
| bus_reset_i | input | 1 | Bus-reset pulse |
| wake_o | output | 1 | Wake-up square wave; 0 when not asserted |

## Verification
The bench builds the block with the default HALF_CYCLES of 4, which is the 8-clock period used in the target system. At that size, several full high/low cycles fit between random events. Restarts, stops in the middle of a half, and bus resets landing in either half are therefore all reached in a short run. The directed cases also place events on edges where the link is awake, and toggle the interrupt enable around a pending interrupt. This exercises both the "not remembered" rule and the bus-reset exception.

// File: rtl/lwake_pkg.sv
package lwake_pkg;

    // Wake-up controller states
    typedef enum logic [1:0] {
        WK_OFF  = 2'd0,
        WK_HIGH = 2'd1,
        WK_LOW  = 2'd2
    } wk_state_e;

endpackage

// File: rtl/lwake_qual.sv
// Combines raw condition inputs into the qualified terms the controller uses.
module lwake_qual (
    input  logic lps_ok_i,
    input  logic lctrl_i,
    input  logic linkon_pulse_i,
    input  logic phy_irq_i,
    input  logic irq_wake_en_i,
    input  logic bus_reset_i,
    output logic link_awake_o,
    output logic wake_event_o,
    output logic irq_hold_o,
    output logic clear_req_o
);

    always_comb begin
        link_awake_o = lps_ok_i & lctrl_i;
        irq_hold_o   = phy_irq_i & irq_wake_en_i;
        wake_event_o = linkon_pulse_i | irq_hold_o;
        clear_req_o  = bus_reset_i & ~irq_hold_o;
    end

endmodule

// File: rtl/lwake_halfcnt.sv
// Half-period counter: restarts on every phase change, flags the last cycle of a half.
module lwake_halfcnt #(
    parameter int HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic half_done_o
);

    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign half_done_o = (cnt_q == LAST);

endmodule

// File: rtl/lwake_fsm.sv
// Wake-up controller state machine.
module lwake_fsm
    import lwake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link_awake_i,
    input  logic wake_event_i,
    input  logic clear_req_i,
    input  logic half_done_i,
    output logic restart_o,
    output logic wake_on_o,
    output logic wake_o
);

    wk_state_e state_q;
    wk_state_e state_n;
    logic      keep_on;

    // Decide whether the indication is on for the next cycle.
    always_comb begin
        keep_on = ~link_awake_i &
                  (wake_event_i | ((state_q != WK_OFF) & ~clear_req_i));
    end

    // Next-state logic: start, fall, rise, stop.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            WK_OFF: begin
                if (keep_on) state_n = WK_HIGH;          // start
            end
            WK_HIGH: begin
                if (!keep_on)         state_n = WK_OFF;  // stop
                else if (half_done_i) state_n = WK_LOW;  // fall
            end
            WK_LOW: begin
                if (!keep_on)         state_n = WK_OFF;  // stop
                else if (half_done_i) state_n = WK_HIGH; // rise
            end
            default: state_n = WK_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WK_OFF;
        else        state_q <= state_n;
    end

    // Outputs
    always_comb begin
        restart_o = (state_n != state_q);
        wake_on_o = (state_q != WK_OFF);
        wake_o    = (state_q == WK_HIGH);
    end

endmodule

// File: rtl/link_wake_gen.sv
// Link wake-up signal generator (top).
module link_wake_gen #(
    parameter int HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_ok_i,
    input  logic lctrl_i,
    input  logic linkon_pulse_i,
    input  logic phy_irq_i,
    input  logic irq_wake_en_i,
    input  logic bus_reset_i,
    output logic wake_o
);

    logic link_awake;
    logic wake_event;
    logic irq_hold;
    logic clear_req;
    logic half_done;
    logic restart;
    logic wake_on;

    lwake_qual qual_i (
        .lps_ok_i       (lps_ok_i),
        .lctrl_i        (lctrl_i),
        .linkon_pulse_i (linkon_pulse_i),
        .phy_irq_i      (phy_irq_i),
        .irq_wake_en_i  (irq_wake_en_i),
        .bus_reset_i    (bus_reset_i),
        .link_awake_o   (link_awake),
        .wake_event_o   (wake_event),
        .irq_hold_o     (irq_hold),
        .clear_req_o    (clear_req)
    );

    lwake_halfcnt #(
        .HALF_CYCLES (HALF_CYCLES)
    ) halfcnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (restart),
        .half_done_o (half_done)
    );

    lwake_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_awake_i (link_awake),
        .wake_event_i (wake_event),
        .clear_req_i  (clear_req),
        .half_done_i  (half_done),
        .restart_o    (restart),
        .wake_on_o    (wake_on),
        .wake_o       (wake_o)
    );

endmodule

// File: rtl/lwake_checker.sv
module lwake_checker #(
    parameter int HALF_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic lps_ok_i,
    input logic lctrl_i,
    input logic linkon_pulse_i,
    input logic phy_irq_i,
    input logic irq_wake_en_i,
    input logic bus_reset_i,
    input logic wake_on,
    input logic wake_o
);

    localparam int RW = $clog2(HALF_CYCLES + 2) + 1;

    logic          prev_q;
    logic [RW-1:0] run_q;
    logic          awake;
    logic          hold;

    assign awake = lps_ok_i & lctrl_i;
    assign hold  = phy_irq_i & irq_wake_en_i;

    // Length of the current run of equal output values while on
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            run_q  <= '0;
        end else begin
            prev_q <= wake_o;
            if (!wake_on)                          run_q <= '0;
            else if (run_q == '0 || wake_o != prev_q) run_q <= RW'(1);
            else                                   run_q <= run_q + 1'b1;
        end
    end

    p_reset_low_r1: assert property (@(posedge clk) $rose(rst_n) |-> !wake_o && !wake_on);

    p_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_on && !awake && linkon_pulse_i) |=> wake_o);

    p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_on && !linkon_pulse_i && !hold) |=> !wake_on);

    p_run_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_on |-> (run_q <= RW'(HALF_CYCLES)));

    p_awake_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        awake |=> (!wake_o && !wake_on));

    p_bus_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_i && !hold && !linkon_pulse_i) |=> !wake_on);

    p_bus_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_on && bus_reset_i && hold && !awake) |=> wake_on);

    p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_on |-> !wake_o);

endmodule

bind link_wake_gen lwake_checker #(
    .HALF_CYCLES (HALF_CYCLES)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .lps_ok_i       (lps_ok_i),
    .lctrl_i        (lctrl_i),
    .linkon_pulse_i (linkon_pulse_i),
    .phy_irq_i      (phy_irq_i),
    .irq_wake_en_i  (irq_wake_en_i),
    .bus_reset_i    (bus_reset_i),
    .wake_on        (wake_on),
    .wake_o         (wake_o)
);

// File: tb/link_wake_gen_tb_top.sv
`timescale 1ns/1ps
module link_wake_gen_tb_top;

    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lps_ok = 1'b0, lctrl = 1'b0, linkon = 1'b0;
    logic irq = 1'b0, irq_en = 1'b0, bus_rst = 1'b0;
    logic wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    bit m_on = 1'b0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    link_wake_gen #(.HALF_CYCLES(HALF)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .lps_ok_i       (lps_ok),
        .lctrl_i        (lctrl),
        .linkon_pulse_i (linkon),
        .phy_irq_i      (irq),
        .irq_wake_en_i  (irq_en),
        .bus_reset_i    (bus_rst),
        .wake_o         (wake)
    );

    function automatic bit f_next_on(bit on, bit l, bit c, bit lk, bit iq, bit en, bit br);
        bit awake, hold;
        awake = l & c;
        hold  = iq & en;
        return !awake && (lk || hold || (on && !(br && !hold)));
    endfunction

    function automatic bit f_exp_out(bit on, int cnt);
        return on && (cnt < HALF);
    endfunction

    task automatic check(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: wake_o=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Advance one clock with current inputs, update model, then compare
    task automatic step(input string tag);
        bit nxt;
        @(posedge clk);
        if (rst_n) begin
            nxt = f_next_on(m_on, lps_ok, lctrl, linkon, irq, irq_en, bus_rst);
            if (nxt && !m_on) m_cnt = 0;
            else if (nxt)     m_cnt = (m_cnt + 1) % (2 * HALF);
            m_on = nxt;
        end else begin
            m_on = 1'b0;
        end
        @(negedge clk);
        check(wake, f_exp_out(m_on, m_cnt), tag);
    endtask

    task automatic quiet();
        linkon = 1'b0; bus_rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(wake, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        step("R1 after reset");

        // R8: events while link awake ignored and not remembered
        lps_ok = 1; lctrl = 1; linkon = 1; irq = 0; irq_en = 0;
        step("R8 event while awake");
        quiet(); lps_ok = 0;
        step("R8 not remembered");
        step("R8 not remembered");

        // R2: control bit low alone makes the link asleep
        lps_ok = 1; lctrl = 0; linkon = 1;
        step("R2 wake with lctrl=0");
        quiet();
        // R5: square wave over several periods
        for (int i = 0; i < 20; i++) step("R5 wave");

        // R6: link becomes awake
        lctrl = 1;
        step("R6 awake stops");
        step("R6 stays off");

        // R4: interrupt gated by enable
        lctrl = 0; irq = 1; irq_en = 0;
        step("R4 irq disabled");
        step("R4 irq disabled");
        irq_en = 1;
        step("R4 irq enabled");
        for (int i = 0; i < 5; i++) step("R5 wave");

        // R7: bus reset kept by pending interrupt, then cleared
        bus_rst = 1;
        step("R7 bus reset held by irq");
        bus_rst = 0; irq = 0;
        step("R7 continue");
        bus_rst = 1;
        step("R7 bus reset clears");
        bus_rst = 0;
        step("R9 stays off");

        // R3: link-on packet restart, high phase first
        linkon = 1;
        step("R3 linkon start");
        quiet();
        for (int i = 0; i < 6; i++) step("R5 wave");
        // R7 in low phase
        bus_rst = 1;
        step("R7 clear in low half");
        quiet();

        // Constrained random
        for (int i = 0; i < 4000; i++) begin
            lps_ok  = ($urandom % 4) != 0;
            lctrl   = ($urandom % 3) != 0;
            linkon  = ($urandom % 12) == 0;
            irq     = ($urandom % 10) == 0;
            irq_en  = ($urandom % 2) == 0;
            bus_rst = ($urandom % 15) == 0;
            step(m_on ? "R5 random" : "R9 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1394);
    end

endmodule